// File: doc/BRIEF.md
# Clock Manager Lock Supervisor

This block sits next to a clock-management unit that multiplies a reference clock, for example a 40 MHz input turned into a 160 MHz synthesized output plus 1x and 2x copies. The unit's reset pin must not be tied to a fixed level. This supervisor drives that reset from logic, so the unit is always reset once after configuration. It then releases the reset and waits a bounded time for the unit to report a trustworthy lock.

The supervisor runs on the free-running reference clock. It brings the unit's lock flag and its status vector onto that clock through a two-flop synchronizer. Lock alone is not trusted. The outputs count as good only when lock is high and neither the "synthesized output stopped" bit nor the "input stopped" bit is set, and this must hold for a run of consecutive cycles. Any later fault puts the unit back into reset. A stopped input parks the supervisor in a back-off state until the input has been quiet for a while. Downstream logic sees a single "clocks good" flag. A saturating counter records how many restarts have occurred.

Top module: `clk_lock_supervisor`

## Requirements
- R1: While the global reset `rst_n` is low, `cm_reset` is 1, `clocks_good` is 0 and `restart_count` is 0.
- R2: After global reset, `cm_reset` stays high for exactly RST_CYCLES reference-clock cycles before it is released.
- R3: `cm_locked` and `cm_status` pass through two flops before any decision. A change driven before clock edge k first affects the registered outputs at edge k+2.
- R4: With the reset released, the supervisor enters the running state only after STABLE_CYCLES consecutive synchronized cycles with lock high and status bits 1 and 2 low. Any break in that run restarts the count from zero.
- R5: `clocks_good` is 1 only in the running state, and `cm_reset` is 0 whenever `clocks_good` is 1.
- R6: If the running state is not reached within LOCK_TIMEOUT cycles after reset release, `cm_reset` is raised again and `restart_count` increments.
- R7: Loss of lock while running raises `cm_reset`, drops `clocks_good` and counts a restart.
- R8: Status bit 2 (synthesized output stopped) set while running causes a restart even though lock stays high.
- R9: Status bit 1 (input stopped) forces a back-off state in which `cm_reset` is held high for as long as the bit is set. Once the bit has been low for STABLE_CYCLES consecutive cycles, the supervisor returns to the reset-hold phase.
- R10: `restart_count` increments by exactly one for each restart out of the waiting or running state, and saturates at its all-ones value (255 for the default 8-bit width).
- R11: Status bit 0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| cm_locked | input | 1 | Lock flag from the clock-management unit (asynchronous) |
| cm_status | input | 3 | Unit status; bit 1 = input stopped, bit 2 = synthesized output stopped, bit 0 unused |
| cm_reset | output | 1 | Reset to the clock-management unit, active high |
| clocks_good | output | 1 | Unit outputs are qualified for downstream use |
| restart_count | output | RCNT_W (8) | Saturating count of restarts |

## Verification
The bench builds the supervisor with RST_CYCLES=4, LOCK_TIMEOUT=40 and STABLE_CYCLES=6. With these values one failed lock attempt lasts 44 cycles, so more than 255 timeouts fit in a short run and the restart counter's saturation can be reached. The short qualification window lets the bench place a one-cycle lock glitch inside a waiting phase and measure exactly how the run count restarts. A behavioural model is compared against all outputs on every cycle, and separate targeted checks pin down the two-cycle synchronizer latency and the back-off exit time.

// File: rtl/clksup_pkg.sv
package clksup_pkg;
  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_WAIT    = 2'd1,
    ST_RUN     = 2'd2,
    ST_BACKOFF = 2'd3
  } sup_state_t;

  // Status bit positions as driven by the clock-management unit
  localparam int IN_STOP_BIT  = 1;
  localparam int OUT_STOP_BIT = 2;
endpackage

// File: rtl/clksup_sync.sv
module clksup_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  // one two-flop chain per bit
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= async_in[b];
        sync_q <= meta_q;
      end
    end
    assign sync_out[b] = sync_q;
  end
endmodule

// File: rtl/clksup_restart_ctr.sv
module clksup_restart_ctr #(
  parameter int RCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_evt,
  output logic [RCNT_W-1:0] count
);
  localparam logic [RCNT_W-1:0] CNT_MAX = '1;

  function automatic logic [RCNT_W-1:0] sat_inc(input logic [RCNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + RCNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count <= '0;
    else if (restart_evt) count <= sat_inc(count);
  end

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX) |=> (count == CNT_MAX));

  // R10
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == $past(count) + RCNT_W'(1)));
endmodule

// File: rtl/clksup_fsm.sv
module clksup_fsm
  import clksup_pkg::*;
#(
  parameter int RST_CYCLES    = 8,
  parameter int LOCK_TIMEOUT  = 65536,
  parameter int STABLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_s,
  input  logic in_stop_s,
  input  logic out_stop_s,
  output logic cm_reset,
  output logic clocks_good,
  output logic restart_evt
);
  localparam int TMR_MAX = (LOCK_TIMEOUT > RST_CYCLES) ? LOCK_TIMEOUT : RST_CYCLES;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int STB_W   = $clog2(STABLE_CYCLES + 1);
  localparam logic [TMR_W-1:0] HOLD_LAST = TMR_W'(RST_CYCLES - 1);
  localparam logic [TMR_W-1:0] WAIT_LAST = TMR_W'(LOCK_TIMEOUT - 1);
  localparam logic [STB_W-1:0] STB_LAST  = STB_W'(STABLE_CYCLES - 1);

  sup_state_t       state, state_n;
  logic [TMR_W-1:0] tmr, tmr_n;
  logic [STB_W-1:0] stb, stb_n;

  // named internal events
  logic qual;        // outputs trustworthy this cycle
  logic hold_done;   // minimum reset width reached
  logic wait_expired;
  logic run_reached;
  logic quiet_done;  // input quiet long enough in back-off

  function automatic logic [STB_W-1:0] run_step(input logic ok, input logic [STB_W-1:0] c);
    return ok ? c + STB_W'(1) : '0;
  endfunction

  assign qual         = lock_s & ~in_stop_s & ~out_stop_s;
  assign hold_done    = (tmr == HOLD_LAST);
  assign wait_expired = (tmr == WAIT_LAST);
  assign run_reached  = qual && (stb == STB_LAST);
  assign quiet_done   = ~in_stop_s && (stb == STB_LAST);

  always_comb begin
    state_n     = state;
    tmr_n       = tmr;
    stb_n       = stb;
    restart_evt = 1'b0;
    case (state)
      ST_HOLD: begin
        if (in_stop_s) begin
          state_n = ST_BACKOFF; tmr_n = '0; stb_n = '0;
        end else if (hold_done) begin
          state_n = ST_WAIT; tmr_n = '0; stb_n = '0;
        end else begin
          tmr_n = tmr + TMR_W'(1);
        end
      end
      ST_WAIT: begin
        if (in_stop_s) begin
          state_n = ST_BACKOFF; restart_evt = 1'b1; tmr_n = '0; stb_n = '0;
        end else if (run_reached) begin
          state_n = ST_RUN; tmr_n = '0; stb_n = '0;
        end else if (wait_expired) begin
          state_n = ST_HOLD; restart_evt = 1'b1; tmr_n = '0; stb_n = '0;
        end else begin
          tmr_n = tmr + TMR_W'(1);
          stb_n = run_step(qual, stb);
        end
      end
      ST_RUN: begin
        if (in_stop_s) begin
          state_n = ST_BACKOFF; restart_evt = 1'b1;
        end else if (!qual) begin
          state_n = ST_HOLD; restart_evt = 1'b1;
        end
        tmr_n = '0;
        stb_n = '0;
      end
      default: begin // ST_BACKOFF
        if (quiet_done) begin
          state_n = ST_HOLD; tmr_n = '0; stb_n = '0;
        end else begin
          stb_n = run_step(~in_stop_s, stb);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HOLD;
      tmr   <= '0;
      stb   <= '0;
    end else begin
      state <= state_n;
      tmr   <= tmr_n;
      stb   <= stb_n;
    end
  end

  assign cm_reset    = (state == ST_HOLD) || (state == ST_BACKOFF);
  assign clocks_good = (state == ST_RUN);

  // R2
  release_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && $past(state) == ST_HOLD) |-> ($past(tmr) == HOLD_LAST));

  // R4
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && $past(state) == ST_WAIT) |-> $past(qual));

  // R7
  lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !lock_s) |=> cm_reset);

  // R8
  out_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && out_stop_s) |=> !clocks_good);

  // R9
  backoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BACKOFF && in_stop_s) |=> (state == ST_BACKOFF));

  // R5
  good_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clocks_good) |-> !cm_reset && $past(state) == ST_WAIT);
endmodule

// File: rtl/clk_lock_supervisor.sv
module clk_lock_supervisor
  import clksup_pkg::*;
#(
  parameter int RST_CYCLES    = 8,
  parameter int LOCK_TIMEOUT  = 65536,
  parameter int STABLE_CYCLES = 16,
  parameter int RCNT_W        = 8
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              cm_locked,
  input  logic [2:0]        cm_status,
  output logic              cm_reset,
  output logic              clocks_good,
  output logic [RCNT_W-1:0] restart_count
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] raw_vec, sync_vec;
  logic              restart_evt;
  logic              status_unused;

  // bit 0 of the status vector carries no decision
  assign status_unused = cm_status[0];
  assign raw_vec = {cm_status[OUT_STOP_BIT], cm_status[IN_STOP_BIT], cm_locked};

  clksup_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .async_in (raw_vec),
    .sync_out (sync_vec)
  );

  clksup_fsm #(
    .RST_CYCLES    (RST_CYCLES),
    .LOCK_TIMEOUT  (LOCK_TIMEOUT),
    .STABLE_CYCLES (STABLE_CYCLES)
  ) u_fsm (
    .clk         (ref_clk),
    .rst_n       (rst_n),
    .lock_s      (sync_vec[0]),
    .in_stop_s   (sync_vec[1]),
    .out_stop_s  (sync_vec[2]),
    .cm_reset    (cm_reset),
    .clocks_good (clocks_good),
    .restart_evt (restart_evt)
  );

  clksup_restart_ctr #(.RCNT_W(RCNT_W)) u_ctr (
    .clk         (ref_clk),
    .rst_n       (rst_n),
    .restart_evt (restart_evt),
    .count       (restart_count)
  );

  // R1
  reset_state_chk: assert property (@(posedge ref_clk)
    !rst_n |-> (cm_reset && !clocks_good && restart_count == '0));
endmodule

// File: tb/clk_lock_supervisor_bench.sv
module clk_lock_supervisor_bench;
  localparam int P_RST = 4;
  localparam int P_TO  = 40;
  localparam int P_STB = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       lock = 1'b0;
  logic [2:0] status = 3'b000;
  logic       cm_reset, clocks_good;
  logic [7:0] restart_count;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_lock_supervisor #(
    .RST_CYCLES(P_RST), .LOCK_TIMEOUT(P_TO), .STABLE_CYCLES(P_STB), .RCNT_W(8)
  ) u_clk_lock_supervisor (
    .ref_clk(clk), .rst_n(rst_n), .cm_locked(lock), .cm_status(status),
    .cm_reset(cm_reset), .clocks_good(clocks_good), .restart_count(restart_count)
  );

  // behavioural reference: phase 0 hold, 1 waiting, 2 running, 3 back-off
  int phase = 0, elapsed = 0, good_run = 0, restarts = 0;
  bit dl[$] = '{0, 0};
  bit di[$] = '{0, 0};
  bit dout[$] = '{0, 0};

  always @(posedge clk) begin
    bit l, i, o, ok;
    if (!rst_n) begin
      phase = 0; elapsed = 0; good_run = 0; restarts = 0;
      dl = '{0, 0}; di = '{0, 0}; dout = '{0, 0};
    end else begin
      l = dl[0]; i = di[0]; o = dout[0];
      ok = l && !i && !o;
      case (phase)
        0: if (i) begin phase = 3; good_run = 0; end
           else if (elapsed + 1 >= P_RST) begin phase = 1; elapsed = 0; good_run = 0; end
           else elapsed++;
        1: if (i) begin phase = 3; good_run = 0; elapsed = 0; restarts++; end
           else if (ok && good_run + 1 >= P_STB) begin phase = 2; elapsed = 0; good_run = 0; end
           else if (elapsed + 1 >= P_TO) begin phase = 0; elapsed = 0; good_run = 0; restarts++; end
           else begin elapsed++; good_run = ok ? good_run + 1 : 0; end
        2: if (i) begin phase = 3; restarts++; end
           else if (!ok) begin phase = 0; elapsed = 0; restarts++; end
        default: if (i) good_run = 0;
           else if (good_run + 1 >= P_STB) begin phase = 0; elapsed = 0; good_run = 0; end
           else good_run++;
      endcase
      if (restarts > 255) restarts = 255;
      void'(dl.pop_front()); dl.push_back(lock);
      void'(di.pop_front()); di.push_back(status[1]);
      void'(dout.pop_front()); dout.push_back(status[2]);
    end
  end

  // cycle compare, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (cm_reset !== (phase == 0 || phase == 3)) begin
        failures++;
        $display("FAIL R2 cycle compare cm_reset act=%0b exp=%0b", cm_reset, (phase == 0 || phase == 3));
      end
      if (clocks_good !== (phase == 2)) begin
        failures++;
        $display("FAIL R5 cycle compare clocks_good act=%0b exp=%0b", clocks_good, (phase == 2));
      end
      if (restart_count !== 8'(restarts)) begin
        failures++;
        $display("FAIL R10 cycle compare restart_count act=%0d exp=%0d", restart_count, restarts);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_good(input string req);
    int n = 0;
    while (!clocks_good && n < 500) begin @(negedge clk); n++; end
    chk(req, clocks_good, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1600000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cm_reset in reset", cm_reset, 1);
    chk("R1 clocks_good in reset", clocks_good, 0);
    chk("R1 restart_count in reset", restart_count, 0);
    rst_n = 1'b1;

    // R2 reset width
    n = 0;
    do begin @(negedge clk); n++; end while (cm_reset && n < 100);
    chk("R2 reset width", n, P_RST);

    // R6 timeout with lock never seen
    repeat (P_TO - 1) @(negedge clk);
    chk("R6 still waiting before timeout", cm_reset, 0);
    @(negedge clk);
    chk("R6 reset reasserted at timeout", cm_reset, 1);
    chk("R6 restart counted", restart_count, 1);

    // R11 lock with status bit 0 set; R4 glitch inside waiting phase
    lock = 1'b1; status = 3'b001;
    while (cm_reset) @(negedge clk);
    repeat (3) @(negedge clk);
    lock = 1'b0;
    @(negedge clk);
    lock = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!clocks_good && n < 100);
    chk("R4 run restarts after glitch", n, P_STB + 2);
    chk("R11 bit0 ignored, good", clocks_good, 1);
    chk("R5 reset low while good", cm_reset, 0);
    repeat (20) @(negedge clk);
    chk("R11 still running with bit0 set", clocks_good, 1);
    status = 3'b000;

    // R3 latency and R7 lock loss
    lock = 1'b0;
    @(negedge clk); chk("R3 no effect after one edge", clocks_good, 1);
    lock = 1'b1;
    @(negedge clk); chk("R3 no effect after two edges", clocks_good, 1);
    @(negedge clk); chk("R7 lock loss drops good", clocks_good, 0);
    chk("R7 lock loss raises reset", cm_reset, 1);
    chk("R7 restart counted", restart_count, 2);
    wait_good("R4 requalify after lock loss");

    // R8 output stopped while lock high
    status = 3'b100;
    repeat (3) @(negedge clk);
    chk("R8 output stop drops good", clocks_good, 0);
    chk("R8 output stop raises reset", cm_reset, 1);
    chk("R8 restart counted", restart_count, 3);
    status = 3'b000;
    wait_good("R8 requalify");

    // R9 input stopped: back-off
    status = 3'b010;
    repeat (3) @(negedge clk);
    chk("R9 input stop drops good", clocks_good, 0);
    chk("R9 restart counted", restart_count, 4);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk("R9 reset held during input stop", cm_reset, 1);
    end
    status = 3'b000;
    n = 0;
    do begin @(negedge clk); n++; end while (cm_reset && n < 100);
    chk("R9 back-off exit plus hold", n, P_STB + 2 + P_RST);
    wait_good("R9 requalify");

    // R10 saturation through repeated timeouts
    lock = 1'b0;
    n = 0;
    while (restart_count != 8'd255 && n < 20000) begin @(negedge clk); n++; end
    chk("R10 reached saturation", restart_count, 255);
    repeat (3 * (P_RST + P_TO)) @(negedge clk);
    chk("R10 stays saturated", restart_count, 255);
    chk("R6 still restarting after saturation", clocks_good, 0);

    finish_run();
  end
endmodule